// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer

This block is a watchdog down-counter of up to 16 bits. It is programmed over a small byte-wide register bus. Software writes a timeout count and picks the tick: one per second or one per minute, both derived from a prescaler on the block clock. The counter then runs down one step per tick. External activity pulses from the infrared receiver, the mouse, the keyboard and the game port can each be allowed to restart the countdown. A restart takes effect after a short fixed delay.

When the count reaches zero, or software forces a timeout, the block latches a sticky reached-zero flag. It drives a fixed-length pulse on each output that the configuration routes: a keyboard-reset style request, a power-good deassertion and a timeout interrupt. The counter then holds at zero until it is reloaded or reprogrammed. Writing a zero timeout stops the watchdog.

The register bus has no handshake. A write is taken on any clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`. Setting parameter `CNT_W` to 8 gives an 8-bit variant without the high count byte.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `kbrst_req` and `tmo_irq` are low, `pwr_good` is high, `irq_line` is 0, and the registers at 0x71, 0x72, 0x73 and 0x74 read 0x00.
- R2: Bytes written to the configuration register (0x72) and the count bytes (0x73 low, 0x74 high) read back unchanged. Register 0x71 reads its reload enables in bits 7:4, reads 0 in bits 3:1, and reads the reached-zero flag in bit 0.
- R3: A write of a count N≠0 to 0x73 or 0x74, taken at edge E, loads the counter at E+1 and restarts the prescaler. Expiry then occurs at edge E+1+N·P. P is TICK_CYC cycles when configuration bit 7 is 1, and TICK_CYC·TICKS_PER_MIN cycles when it is 0.
- R4: At expiry, each output is active for exactly PULSE_CYC cycles when its route bit is set in 0x72: `kbrst_req` high (bit 6), `tmo_irq` high (bit 5), `pwr_good` low (bit 4). An output whose route bit is clear stays idle.
- R5: Expiry sets bit 0 of 0x71, whether or not any output is routed. The bit stays set until exactly 0x00 is written to 0x71; a write of any other value leaves it set.
- R6: After expiry the counter stays at zero, and no further expiry occurs without a reload or a new count.
- R7: When the programmed count becomes zero, the watchdog stops. No expiry follows, and a reload that is pending is dropped.
- R8: A pulse on an event input, sampled at edge E while its enable in 0x71 is set and the count is nonzero, reloads the counter and restarts the prescaler at E+RELOAD_CYC. The enables are bit 7 infrared, bit 6 mouse, bit 5 keyboard and bit 4 game port. Expiry then follows after N·P more cycles. Events that arrive while a reload is pending are ignored.
- R9: An event whose enable bit is clear has no effect on the time of expiry.
- R10: A write to 0x71 with bit 1 set, taken at edge E, causes expiry at E+1 whatever the count, including when the watchdog is stopped. The force bit always reads back 0.
- R11: `irq_line` always equals bits 3:0 of the configuration register.
- R12: An enabled event after expiry restarts the countdown from the programmed count, giving a new expiry RELOAD_CYC+N·P cycles after the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ev_ir | input | 1 | Infrared receiver interrupt pulse |
| ev_mouse | input | 1 | Mouse interrupt pulse |
| ev_kbd | input | 1 | Keyboard interrupt pulse |
| ev_game | input | 1 | Game-port access pulse |
| kbrst_req | output | 1 | Keyboard-reset style request pulse |
| pwr_good | output | 1 | Power-good, driven low for the expiry pulse |
| tmo_irq | output | 1 | Timeout interrupt pulse |
| irq_line | output | 4 | Selected interrupt line number |

## Verification
Nearly every internal fault shows up as a shift in the edge at which the expiry pulse first appears. A prescaler that fails to restart, a reload delay that is off by one, a decrement that is skipped or an event that is accepted when it should be ignored each moves that edge. The edge is therefore compared exactly against a value computed from the write or event edge. A wrong route latch or pulse counter shows within PULSE_CYC cycles of expiry, as a wrong pulse width or a pulse on the wrong output. A wrong flag state shows on the next read of 0x71.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h71;
  localparam logic [7:0] ADDR_CFG  = 8'h72;
  localparam logic [7:0] ADDR_TLO  = 8'h73;
  localparam logic [7:0] ADDR_THI  = 8'h74;

  // configuration byte, field order fixed by the register layout
  typedef struct packed {
    logic       sec_base;
    logic       route_kb;
    logic       irq_en;
    logic       route_pg;
    logic [3:0] irq_sel;
  } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             zero_flag,
  output cfg_t             cfg_o,
  output logic [3:0]       en_o,
  output logic [CNT_W-1:0] prog_o,
  output logic             load_o,
  output logic             force_o,
  output logic             clr_o
);
  localparam bit HAS_HI = (CNT_W > 8);

  logic [7:0] tlo;
  logic [7:0] hi_rd;
  logic       wr_ctrl, wr_cfg, wr_tlo, wr_thi;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_CFG);
  assign wr_tlo  = bus_wr && (bus_addr == ADDR_TLO);

  generate
    if (HAS_HI) begin : g_hi
      logic [7:0] thi;
      assign wr_thi = bus_wr && (bus_addr == ADDR_THI);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thi <= '0;
        else if (wr_thi) thi <= bus_wdata;
      end
      assign hi_rd  = thi;
      assign prog_o = {thi, tlo};
    end else begin : g_lo
      assign wr_thi = 1'b0;
      assign hi_rd  = 8'h00;
      assign prog_o = tlo;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      cfg_o   <= '0;
      tlo     <= '0;
      load_o  <= 1'b0;
      force_o <= 1'b0;
      clr_o   <= 1'b0;
    end else begin
      load_o  <= wr_tlo || wr_thi;
      force_o <= wr_ctrl && bus_wdata[1];
      clr_o   <= wr_ctrl && (bus_wdata == 8'h00);
      if (wr_ctrl) en_o  <= bus_wdata[7:4];
      if (wr_cfg)  cfg_o <= cfg_t'(bus_wdata);
      if (wr_tlo)  tlo   <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {en_o, 3'b000, zero_flag};
      ADDR_CFG:  bus_rdata = cfg_o;
      ADDR_TLO:  bus_rdata = tlo;
      ADDR_THI:  bus_rdata = hi_rd;
      default:   bus_rdata = 8'h00;
    endcase
  end

  // R10: a force strobe only follows a control write
  p_force_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |-> $past(wr_ctrl));
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TICK_CYC      = 32768,
  parameter int TICKS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sec_mode,
  output logic tick_o
);
  localparam int PW = $clog2(TICK_CYC + 1);
  localparam int MW = $clog2(TICKS_PER_MIN + 1);

  logic [PW-1:0] pc;
  logic [MW-1:0] mc;
  logic          sec_wrap, min_wrap;

  assign sec_wrap = (pc == PW'(TICK_CYC - 1));
  assign min_wrap = sec_wrap && (mc == MW'(TICKS_PER_MIN - 1));
  assign tick_o   = sec_mode ? sec_wrap : min_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      mc <= '0;
    end else if (restart) begin
      pc <= '0;
      mc <= '0;
    end else begin
      pc <= sec_wrap ? '0 : pc + PW'(1);
      if (sec_wrap) mc <= min_wrap ? '0 : mc + MW'(1);
    end
  end

  // R3: both stages stay inside their periods
  p_pc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc < PW'(TICK_CYC)) && (mc < MW'(TICKS_PER_MIN)));
  // R3/R8: a restart leaves the prescaler at phase zero
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pc == '0) && (mc == '0));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W      = 16,
  parameter int PULSE_CYC  = 64,
  parameter int RELOAD_CYC = 164
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prog,
  input  logic             load,
  input  logic             force_exp,
  input  logic             clr,
  input  logic             tick,
  input  logic             ev_hit,
  input  logic             route_kb,
  input  logic             route_pg,
  input  logic             irq_en,
  output logic             restart,
  output logic             zero_flag,
  output logic             kbrst,
  output logic             pwr_good,
  output logic             irq
);
  localparam int DW = $clog2(RELOAD_CYC + 1);
  localparam int LW = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    dly;
  logic [LW-1:0]    pls;
  logic             kb_q, pg_q, irq_q;
  logic             reload_now, expire;

  assign reload_now = (dly == DW'(1));
  assign restart    = load || reload_now;
  assign expire     = !load && (force_exp ||
                      (tick && !reload_now && (cnt == CNT_W'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dly <= '0;
    end else if (load) begin
      cnt <= prog;
      dly <= '0;
    end else if (force_exp) begin
      cnt <= '0;
      dly <= '0;
    end else if (reload_now) begin
      cnt <= prog;
      dly <= '0;
    end else begin
      if (tick && (cnt != '0)) cnt <= cnt - CNT_W'(1);
      if (dly != '0)                  dly <= dly - DW'(1);
      else if (ev_hit && (prog != '0)) dly <= DW'(RELOAD_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_flag <= 1'b0;
      pls       <= '0;
      kb_q      <= 1'b0;
      pg_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (expire)   zero_flag <= 1'b1;
      else if (clr) zero_flag <= 1'b0;
      if (expire) begin
        pls   <= LW'(PULSE_CYC);
        kb_q  <= route_kb;
        pg_q  <= route_pg;
        irq_q <= irq_en;
      end else if (pls != '0) begin
        pls <= pls - LW'(1);
        if (pls == LW'(1)) begin
          kb_q  <= 1'b0;
          pg_q  <= 1'b0;
          irq_q <= 1'b0;
        end
      end
    end
  end

  assign kbrst    = kb_q;
  assign pwr_good = !pg_q;
  assign irq      = irq_q;

  // R6: an expired counter holds zero until loaded or reloaded
  p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && !load && !reload_now |=> (cnt == '0));
  // R7: a zero count leaves nothing running or pending
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (prog == '0)) |=> (cnt == '0) && (dly == '0));
  // R5: the flag persists until an explicit clear
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag && !clr |=> zero_flag);
  // R4: outputs are idle whenever no pulse is in progress
  p_idle_outs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pls == '0) |-> !kb_q && !pg_q && !irq_q);
  // R10: forcing leaves a zero count and a set flag
  p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (force_exp && !load) |=> zero_flag && (cnt == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int TICK_CYC      = 32768,
  parameter int TICKS_PER_MIN = 60,
  parameter int CNT_W         = 16,
  parameter int PULSE_CYC     = 64,
  parameter int RELOAD_CYC    = 164
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ev_ir,
  input  logic       ev_mouse,
  input  logic       ev_kbd,
  input  logic       ev_game,
  output logic       kbrst_req,
  output logic       pwr_good,
  output logic       tmo_irq,
  output logic [3:0] irq_line
);
  cfg_t             cfg;
  logic [3:0]       en;
  logic [CNT_W-1:0] prog;
  logic             load, force_exp, clr, tick, restart, zero_flag, ev_hit;

  assign ev_hit   = |(en & {ev_ir, ev_mouse, ev_kbd, ev_game});
  assign irq_line = cfg.irq_sel;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .zero_flag(zero_flag),
    .cfg_o(cfg), .en_o(en), .prog_o(prog), .load_o(load),
    .force_o(force_exp), .clr_o(clr)
  );

  wdog_prescale #(.TICK_CYC(TICK_CYC), .TICKS_PER_MIN(TICKS_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sec_mode(cfg.sec_base),
    .tick_o(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .PULSE_CYC(PULSE_CYC), .RELOAD_CYC(RELOAD_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .prog(prog), .load(load), .force_exp(force_exp),
    .clr(clr), .tick(tick), .ev_hit(ev_hit), .route_kb(cfg.route_kb),
    .route_pg(cfg.route_pg), .irq_en(cfg.irq_en), .restart(restart),
    .zero_flag(zero_flag), .kbrst(kbrst_req), .pwr_good(pwr_good), .irq(tmo_irq)
  );
endmodule

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  localparam int TC = 5, TPM = 3, PL = 4, RD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic bus_wr = 1'b0;
  logic ev_ir = 1'b0, ev_mouse = 1'b0, ev_kbd = 1'b0, ev_game = 1'b0;
  logic [7:0] bus_rdata;
  logic kbrst_req, pwr_good, tmo_irq;
  logic [3:0] irq_line;
  int cyc = 0, n_cmp = 0, n_bad = 0, last_edge = 0;

  wdog_timer #(.TICK_CYC(TC), .TICKS_PER_MIN(TPM), .CNT_W(16),
               .PULSE_CYC(PL), .RELOAD_CYC(RD)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ir(ev_ir),
    .ev_mouse(ev_mouse), .ev_kbd(ev_kbd), .ev_game(ev_game),
    .kbrst_req(kbrst_req), .pwr_good(pwr_good), .tmo_irq(tmo_irq),
    .irq_line(irq_line)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period(input int sec);
    return (sec != 0) ? TC : TC * TPM;
  endfunction
  function automatic int exp_load(input int e, input int n, input int sec);
    return e + 1 + n * period(sec);
  endfunction
  function automatic int exp_reload(input int e, input int n, input int sec);
    return e + RD + n * period(sec);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic set_tmo(input logic [7:0] n);
    wr(8'h74, 8'h00);
    wr(8'h73, n);
  endtask

  task automatic fire(input int idx);
    @(negedge clk);
    case (idx)
      0: ev_ir = 1'b1;
      1: ev_mouse = 1'b1;
      2: ev_kbd = 1'b1;
      default: ev_game = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    ev_ir = 1'b0; ev_mouse = 1'b0; ev_kbd = 1'b0; ev_game = 1'b0;
    last_edge = cyc;
  endtask

  task automatic wait_exp(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      if (kbrst_req || !pwr_good || tmo_irq) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulses(output int nk, output int np, output int ni);
    nk = 0; np = 0; ni = 0;
    for (int i = 0; i < PL + 3; i++) begin
      if (kbrst_req) nk++;
      if (!pwr_good) np++;
      if (tmo_irq) ni++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int at, d, nk, np, ni, e, ev, n, sec, pg, iq, line, cfgb, enm, idx, k;
    int unsigned seed;
    seed = $urandom(32'd7351);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 kbrst_req", int'(kbrst_req), 0);
    chk("R1 pwr_good", int'(pwr_good), 1);
    chk("R1 tmo_irq", int'(tmo_irq), 0);
    chk("R1 irq_line", int'(irq_line), 0);
    for (int a = 8'h71; a <= 8'h74; a++) begin
      rd(8'(a), d);
      chk("R1 register", d, 0);
    end

    // R2 / R11 readback
    wr(8'h72, 8'hC5); rd(8'h72, d); chk("R2 cfg", d, 8'hC5);
    chk("R11 irq_line", int'(irq_line), 5);
    wr(8'h71, 8'hF0); rd(8'h71, d); chk("R2 ctrl enables", d, 8'hF0);
    wr(8'h71, 8'h0C); rd(8'h71, d); chk("R2 ctrl unused bits", d, 8'h00);
    wr(8'h74, 8'h12); wr(8'h73, 8'h34);
    rd(8'h73, d); chk("R2 low byte", d, 8'h34);
    rd(8'h74, d); chk("R2 high byte", d, 8'h12);
    wr(8'h73, 8'h00); wr(8'h74, 8'h00);

    // R3 seconds timebase, R4 keyboard route
    wr(8'h72, 8'hC0); set_tmo(8'd3); e = last_edge;
    wait_exp(200, at); chk("R3 seconds expiry", at, exp_load(e, 3, 1));
    pulses(nk, np, ni);
    chk("R4 kbrst width", nk, PL); chk("R4 pg unrouted", np, 0); chk("R4 irq unrouted", ni, 0);

    // R5 sticky flag
    rd(8'h71, d); chk("R5 flag set", d, 8'h01);
    wr(8'h71, 8'h10); rd(8'h71, d); chk("R5 nonzero write keeps", d, 8'h11);
    wr(8'h71, 8'h00); rd(8'h71, d); chk("R5 zero write clears", d, 8'h00);

    // R6 hold at zero
    wait_exp(60, at); chk("R6 no second expiry", at, -1);

    // R3 minutes timebase
    wr(8'h72, 8'h40); set_tmo(8'd2); e = last_edge;
    wait_exp(200, at); chk("R3 minutes expiry", at, exp_load(e, 2, 0));
    pulses(nk, np, ni);

    // R4 power-good only, irq only
    wr(8'h72, 8'h90); set_tmo(8'd1); e = last_edge;
    wait_exp(100, at); chk("R4 pg expiry time", at, exp_load(e, 1, 1));
    pulses(nk, np, ni);
    chk("R4 pg width", np, PL); chk("R4 kbrst unrouted", nk, 0); chk("R4 irq unrouted", ni, 0);
    wr(8'h72, 8'hA0); set_tmo(8'd1); e = last_edge;
    wait_exp(100, at); chk("R4 irq expiry time", at, exp_load(e, 1, 1));
    pulses(nk, np, ni);
    chk("R4 irq width", ni, PL); chk("R4 kbrst unrouted", nk, 0); chk("R4 pg unrouted", np, 0);

    // R4/R5 no route: silent outputs but flag set
    wr(8'h71, 8'h00); wr(8'h72, 8'h80); set_tmo(8'd1);
    wait_exp(40, at); chk("R4 no route silent", at, -1);
    rd(8'h71, d); chk("R5 flag without route", d, 8'h01);
    wr(8'h71, 8'h00);

    // R7 stop with a pending reload
    wr(8'h72, 8'hC0); wr(8'h71, 8'h10); set_tmo(8'd2); fire(3);
    set_tmo(8'd0);
    wait_exp(100, at); chk("R7 stopped", at, -1);

    // R8 reload from infrared event
    wr(8'h71, 8'h80); set_tmo(8'd4); repeat (6) @(negedge clk);
    fire(0); ev = last_edge;
    wait_exp(200, at); chk("R8 reload", at, exp_reload(ev, 4, 1));
    pulses(nk, np, ni);

    // R8 second event during pending reload is ignored
    wr(8'h71, 8'h40); set_tmo(8'd4); repeat (4) @(negedge clk);
    fire(1); ev = last_edge; fire(1);
    wait_exp(200, at); chk("R8 pending ignores", at, exp_reload(ev, 4, 1));
    pulses(nk, np, ni);

    // R9 disabled event
    wr(8'h71, 8'h10); set_tmo(8'd4); e = last_edge;
    repeat (6) @(negedge clk); fire(2);
    wait_exp(200, at); chk("R9 disabled event", at, exp_load(e, 4, 1));
    pulses(nk, np, ni);

    // R12 reload after expiry
    set_tmo(8'd2); wait_exp(200, at); pulses(nk, np, ni);
    repeat (3) @(negedge clk);
    fire(3); ev = last_edge;
    wait_exp(200, at); chk("R12 restart after expiry", at, exp_reload(ev, 2, 1));
    pulses(nk, np, ni);

    // R10 force while stopped and while running
    set_tmo(8'd0); wr(8'h71, 8'h00); wr(8'h71, 8'h02); e = last_edge;
    wait_exp(20, at); chk("R10 force stopped", at, e + 1);
    pulses(nk, np, ni); chk("R10 force pulse", nk, PL);
    rd(8'h71, d); chk("R10 force reads 0", d, 8'h01);
    wr(8'h71, 8'h00); set_tmo(8'd9); repeat (3) @(negedge clk);
    wr(8'h71, 8'h02); e = last_edge;
    wait_exp(20, at); chk("R10 force running", at, e + 1);
    pulses(nk, np, ni);

    // constrained random timing, routing and events
    for (int it = 0; it < 16; it++) begin
      n    = 1 + int'($urandom % 5);
      sec  = int'($urandom % 2);
      pg   = int'($urandom % 2);
      iq   = int'($urandom % 2);
      line = int'($urandom % 16);
      enm  = int'($urandom % 16);
      idx  = int'($urandom % 4);
      cfgb = (sec << 7) | (1 << 6) | (iq << 5) | (pg << 4) | line;
      wr(8'h71, 8'(enm << 4));
      wr(8'h72, 8'(cfgb));
      chk("R11 irq_line random", int'(irq_line), line);
      set_tmo(8'(n)); e = last_edge;
      if (n >= 2 && ($urandom % 2) == 1) begin
        k = int'($urandom % (n * period(sec) - RD - 2));
        repeat (k) @(negedge clk);
        fire(idx); ev = last_edge;
        wait_exp(400, at);
        if (((enm >> (3 - idx)) & 1) == 1)
          chk("R8 random reload", at, exp_reload(ev, n, sec));
        else
          chk("R9 random disabled", at, exp_load(e, n, sec));
      end else begin
        wait_exp(400, at);
        chk("R3 random expiry", at, exp_load(e, n, sec));
      end
      pulses(nk, np, ni);
      chk("R4 random kbrst", nk, PL);
      chk("R4 random pg", np, (pg != 0) ? PL : 0);
      chk("R4 random irq", ni, (iq != 0) ? PL : 0);
      rd(8'h71, d);
      chk("R5 random flag", d & 1, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule